// File: doc/BRIEF.md
# Serial Flash Deep Power-Down and Signature Responder

This block is the command front end of a serial memory slave that uses SPI mode 0 framing (clock idles low, input sampled on the rising clock edge, output changed on the falling edge). It watches the select, serial clock and serial input pins from the system clock domain and recognises two instructions. One puts the memory into a deep power-down state. The other wakes the memory and returns an 8-bit identification value.

While the memory is powered down, the block drops every other instruction. The identification instruction can also be used in normal operation. It is refused while an external erase, program or status-write engine reports busy. Waking from power-down does not return the memory to standby at once: a hold-off timer keeps the status output not-ready for a parameterised number of system clock cycles.

Top module: `flash_pd_sig_resp`

## Requirements
- R1: After reset the block is in standby: `ready_o`=1, `pd_o`=0, `so_oe_o`=0.
- R2: Opcode 0xB9 shifted in MSB first, followed by select going high after exactly 8 rising clock edges, puts the block into power-down (`pd_o`=1, `ready_o`=0). With 7 or 9 edges the state does not change.
- R3: While powered down, every opcode other than 0xAB (including 0xB9, 0x9F and 0x03) leaves `pd_o`=1 and never enables the output.
- R4: Opcode 0xAB, followed by 24 don't-care bits, makes the block drive the signature 0x13 MSB first. Each bit changes after a falling serial clock edge, and the first bit follows the 32nd rising edge.
- R5: While select stays low and clocking continues, the 8-bit signature repeats without limit.
- R6: `so_oe_o` stays 0 during the opcode and dummy bits and whenever select is high.
- R7: When 0xAB is issued in standby, `ready_o` stays 1 and a new command is accepted right after select goes high.
- R8: When 0xAB is issued in power-down, the signature is still returned. After select goes high, `pd_o` drops and `ready_o` stays 0 for WAKE_CYCLES system clocks, then returns to 1.
- R9: During the wake hold-off, instructions are not decoded. A 0xB9 sent in that window has no effect.
- R10: If `busy_i` is high when the eighth opcode bit is taken, 0xAB and 0xB9 are not decoded: there is no output and no change of power state.
- R11: Select going high discards a partial instruction. The next instruction is decoded from its own first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n_i | input | 1 | Chip select pin, active low |
| sck_i | input | 1 | Serial clock pin |
| mosi_i | input | 1 | Serial data input pin |
| busy_i | input | 1 | Erase/program/status-write cycle in progress |
| so_o | output | 1 | Serial data output value |
| so_oe_o | output | 1 | Serial data output enable (0 = high impedance) |
| ready_o | output | 1 | Standby and able to accept commands |
| pd_o | output | 1 | Deep power-down active |

## Verification
Each pin edge becomes visible after the two synchroniser stages plus one edge register. A signature bit therefore appears about four system clocks after its falling serial clock edge. The bench runs each serial half period for eight system clocks and samples the output just before the next rising edge, which leaves a margin of several cycles. Power state changes land three cycles after select rises. The wake check reads `ready_o` ten cycles before WAKE_CYCLES has elapsed and twenty cycles after, so it does not depend on the exact edge. Signature bytes from the driver are queued, and a monitor compares them in order as they are assembled.

// File: rtl/flash_pd_pkg.sv
package flash_pd_pkg;

    typedef enum logic [1:0] {
        PWR_ACTIVE = 2'd0,
        PWR_DEEP   = 2'd1,
        PWR_WAKING = 2'd2
    } pwr_e;

    localparam int unsigned OP_BITS    = 8;
    localparam int unsigned DUMMY_BITS = 24;

    localparam logic [7:0] OPC_WAKE_SIG = 8'hAB;
    localparam logic [7:0] OPC_DEEP_PD  = 8'hB9;

endpackage

// File: rtl/fpd_pin_sync.sv
module fpd_pin_sync #(
    parameter int unsigned      WIDTH   = 3,
    parameter int unsigned      STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] lvl_o
);

    typedef logic [STAGES-1:0][WIDTH-1:0] pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = raw_i;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= {STAGES{RST_VAL}};
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign lvl_o = pipe_q[STAGES-1];

endmodule

// File: rtl/fpd_cmd_shift.sv
module fpd_cmd_shift
    import flash_pd_pkg::*;
#(
    parameter logic [7:0] SIG_VALUE = 8'h13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_lvl_i,
    input  logic sck_lvl_i,
    input  logic mosi_lvl_i,
    input  logic busy_i,
    input  pwr_e pwr_i,
    output logic cs_rise_o,
    output logic res_o,
    output logic dpd_o,
    output logic so_o,
    output logic so_oe_o
);

    localparam int unsigned CNT_CAP = OP_BITS + DUMMY_BITS;
    localparam int unsigned CW      = $clog2(CNT_CAP + 1);
    localparam logic [CW-1:0] CNT_OP   = CW'(OP_BITS);
    localparam logic [CW-1:0] CNT_LAST = CW'(OP_BITS - 1);
    localparam logic [CW-1:0] CNT_SIG  = CW'(CNT_CAP);

    typedef struct packed {
        logic          sel_p;
        logic          sck_p;
        logic [CW-1:0] cnt;
        logic [7:0]    op;
        logic          res;
        logic          dpd;
        logic [2:0]    idx;
        logic          so;
        logic          oe;
    } sh_t;

    sh_t sh_d, sh_q;

    logic       sck_rise, sck_fall;
    logic [7:0] op_full;

    assign sck_rise = sck_lvl_i & ~sh_q.sck_p;
    assign sck_fall = ~sck_lvl_i & sh_q.sck_p;
    assign op_full  = {sh_q.op[6:0], mosi_lvl_i};

    always_comb begin
        sh_d = sh_q;
        if (sel_lvl_i) begin
            sh_d = '0;
        end else begin
            if (sck_rise) begin
                if (sh_q.cnt != CNT_SIG) begin
                    sh_d.cnt = sh_q.cnt + 1'b1;
                end
                if (sh_q.cnt < CNT_OP) begin
                    sh_d.op = op_full;
                end
                if (sh_q.cnt == CNT_LAST) begin
                    sh_d.res = (op_full == OPC_WAKE_SIG) && !busy_i
                               && (pwr_i != PWR_WAKING);
                    sh_d.dpd = (op_full == OPC_DEEP_PD) && !busy_i
                               && (pwr_i == PWR_ACTIVE);
                end
            end
            if (sck_fall && sh_q.res && (sh_q.cnt == CNT_SIG)) begin
                sh_d.oe  = 1'b1;
                sh_d.so  = SIG_VALUE[3'd7 - sh_q.idx];
                sh_d.idx = sh_q.idx + 3'd1;
            end
        end
        sh_d.sel_p = sel_lvl_i;
        sh_d.sck_p = sck_lvl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q       <= '0;
            sh_q.sel_p <= 1'b1;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign cs_rise_o = sel_lvl_i & ~sh_q.sel_p;
    assign res_o     = sh_q.res;
    assign dpd_o     = sh_q.dpd && (sh_q.cnt == CNT_OP);
    assign so_o      = sh_q.so;
    assign so_oe_o   = sh_q.oe;

    // R6: deselect always releases the output
    a_r6_hiz_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        sel_lvl_i |=> !sh_q.oe);

    // R6: driving begins only once opcode and dummy bits are complete
    a_r6_drive_after_dummy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sh_q.oe) |-> (sh_q.cnt == CNT_SIG));

    // R4: output enable only under a decoded signature command
    a_r4_drive_needs_decode: assert property (@(posedge clk) disable iff (!rst_n)
        sh_q.oe |-> sh_q.res);

    // R10: busy engine blocks decode on the eighth bit
    a_r10_busy_blocks_decode: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_lvl_i && sck_rise && (sh_q.cnt == CNT_LAST) && busy_i)
        |=> (!sh_q.res && !sh_q.dpd));

endmodule

// File: rtl/fpd_pwr_ctrl.sv
module fpd_pwr_ctrl
    import flash_pd_pkg::*;
#(
    parameter int unsigned WAKE_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_rise_i,
    input  logic res_i,
    input  logic dpd_i,
    output pwr_e pwr_o,
    output logic ready_o,
    output logic pd_o
);

    localparam int unsigned TW = $clog2(WAKE_CYCLES + 1);
    localparam logic [TW-1:0] TMR_LOAD = TW'(WAKE_CYCLES - 1);

    typedef struct packed {
        pwr_e          st;
        logic [TW-1:0] tmr;
    } pw_t;

    pw_t pw_d, pw_q;

    always_comb begin
        pw_d = pw_q;
        case (pw_q.st)
            PWR_ACTIVE: begin
                if (cs_rise_i && dpd_i) begin
                    pw_d.st = PWR_DEEP;
                end
            end
            PWR_DEEP: begin
                if (cs_rise_i && res_i) begin
                    pw_d.st  = PWR_WAKING;
                    pw_d.tmr = TMR_LOAD;
                end
            end
            PWR_WAKING: begin
                if (pw_q.tmr == '0) begin
                    pw_d.st = PWR_ACTIVE;
                end else begin
                    pw_d.tmr = pw_q.tmr - 1'b1;
                end
            end
            default: pw_d.st = PWR_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pw_q.st  <= PWR_ACTIVE;
            pw_q.tmr <= '0;
        end else begin
            pw_q <= pw_d;
        end
    end

    assign pwr_o   = pw_q.st;
    assign ready_o = (pw_q.st == PWR_ACTIVE);
    assign pd_o    = (pw_q.st == PWR_DEEP);

    // R2: standby is left only on a deselect edge
    a_r2_entry_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        ((pw_q.st == PWR_ACTIVE) && !cs_rise_i) |=> (pw_q.st == PWR_ACTIVE));

    // R3: power-down exits only into the wake hold-off
    a_r3_deep_exits_to_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (pw_q.st == PWR_DEEP) |=> (pw_q.st == PWR_DEEP || pw_q.st == PWR_WAKING));

    // R8: hold-off lasts until the timer has run out
    a_r8_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ((pw_q.st == PWR_WAKING) && (pw_q.tmr != '0)) |=> (pw_q.st == PWR_WAKING));

    // R9: no power-down entry straight from the hold-off
    a_r9_no_entry_from_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (pw_q.st == PWR_WAKING) |=> (pw_q.st != PWR_DEEP));

endmodule

// File: rtl/flash_pd_sig_resp.sv
module flash_pd_sig_resp
    import flash_pd_pkg::*;
#(
    parameter int unsigned WAKE_CYCLES = 1000,
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [7:0]  SIG_VALUE   = 8'h13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_n_i,
    input  logic sck_i,
    input  logic mosi_i,
    input  logic busy_i,
    output logic so_o,
    output logic so_oe_o,
    output logic ready_o,
    output logic pd_o
);

    localparam int unsigned PIN_W = 3;

    logic [PIN_W-1:0] pins_lvl;
    logic             cs_rise, res_seen, dpd_exact;
    pwr_e             pwr;

    fpd_pin_sync #(
        .WIDTH   (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b001)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i ({mosi_i, sck_i, sel_n_i}),
        .lvl_o (pins_lvl)
    );

    fpd_cmd_shift #(
        .SIG_VALUE (SIG_VALUE)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_lvl_i  (pins_lvl[0]),
        .sck_lvl_i  (pins_lvl[1]),
        .mosi_lvl_i (pins_lvl[2]),
        .busy_i     (busy_i),
        .pwr_i      (pwr),
        .cs_rise_o  (cs_rise),
        .res_o      (res_seen),
        .dpd_o      (dpd_exact),
        .so_o       (so_o),
        .so_oe_o    (so_oe_o)
    );

    fpd_pwr_ctrl #(
        .WAKE_CYCLES (WAKE_CYCLES)
    ) u_pwr (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_rise_i (cs_rise),
        .res_i     (res_seen),
        .dpd_i     (dpd_exact),
        .pwr_o     (pwr),
        .ready_o   (ready_o),
        .pd_o      (pd_o)
    );

endmodule

// File: tb/flash_pd_sig_resp_tb.sv
module flash_pd_sig_resp_tb_top;

    localparam int WAKE = 600;
    localparam int HALF = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, sel_n, sck, mosi, busy;
    logic so, so_oe, ready, pd;

    flash_pd_sig_resp #(.WAKE_CYCLES(WAKE)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_n_i (sel_n),
        .sck_i   (sck),
        .mosi_i  (mosi),
        .busy_i  (busy),
        .so_o    (so),
        .so_oe_o (so_oe),
        .ready_o (ready),
        .pd_o    (pd)
    );

    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;
    longint cyc   = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        logic [7:0] v;
        string      req;
    } item_t;

    item_t      exp_q[$];
    logic [7:0] act_q[$];

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: queues expected signature bytes, shifts the command, gathers output
    task automatic xfer(input logic [7:0] opc, input int nbits, input int nsig, input string req);
        logic [7:0] acc = '0;
        int rd = 0;
        for (int k = 0; k < nsig; k++) exp_q.push_back('{8'h13, req});
        sel_n = 1'b0;
        wait_clk(HALF);
        for (int b = 0; b < nbits; b++) begin
            mosi = (b < 8) ? opc[7-b] : (b[0] ^ b[2]);
            wait_clk(HALF);
            if (nsig > 0 && b >= 32) begin
                acc = {acc[6:0], so};
                rd++;
                chk(32'(so_oe), 1, req);
                if (rd % 8 == 0) act_q.push_back(acc);
            end else begin
                chk(32'(so_oe), 0, (nsig > 0) ? "R6" : req);
            end
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
        end
        wait_clk(HALF);
        sel_n = 1'b1;
        wait_clk(6);
        chk(32'(so_oe), 0, "R6");
    endtask

    // monitor: pairs produced bytes with expected ones in order
    initial begin
        forever begin
            @(negedge clk);
            while (act_q.size() > 0) begin
                if (exp_q.size() == 0) begin
                    chk(32'(act_q.pop_front()), 32'hFFFF, "R4 unexpected byte");
                end else begin
                    item_t e;
                    e = exp_q.pop_front();
                    chk(32'(act_q.pop_front()), 32'(e.v), e.req);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        longint t0;
        rst_n = 1'b0; sel_n = 1'b1; sck = 1'b0; mosi = 1'b0; busy = 1'b0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        // R1 reset state
        chk(32'(ready), 1, "R1");
        chk(32'(pd), 0, "R1");
        chk(32'(so_oe), 0, "R1");

        // R4 R5 R7: signature in standby, three repeats
        xfer(8'hAB, 32 + 24, 3, "R5");
        chk(32'(ready), 1, "R7");
        chk(32'(pd), 0, "R7");

        // R2: wrong lengths then exact length
        xfer(8'hB9, 9, 0, "R2");
        chk(32'(pd), 0, "R2");
        xfer(8'hB9, 7, 0, "R2");
        chk(32'(pd), 0, "R2");
        xfer(8'hB9, 8, 0, "R2");
        chk(32'(pd), 1, "R2");
        chk(32'(ready), 0, "R2");

        // R3: other opcodes dropped while powered down
        xfer(8'h9F, 8, 0, "R3");
        chk(32'(pd), 1, "R3");
        xfer(8'hB9, 8, 0, "R3");
        chk(32'(pd), 1, "R3");
        xfer(8'h03, 40, 0, "R3");
        chk(32'(pd), 1, "R3");

        // R10: busy blocks the wake command
        busy = 1'b1;
        xfer(8'hAB, 40, 0, "R10");
        chk(32'(pd), 1, "R10");
        busy = 1'b0;

        // R4 R8: signature from power-down, then hold-off
        xfer(8'hAB, 40, 1, "R4");
        t0 = cyc - 6;
        chk(32'(pd), 0, "R8");
        chk(32'(ready), 0, "R8");
        // R9: command during hold-off ignored
        xfer(8'hB9, 8, 0, "R9");
        chk(32'(ready), 0, "R8");
        while (cyc < t0 + WAKE - 10) @(negedge clk);
        chk(32'(ready), 0, "R8");
        while (cyc < t0 + WAKE + 20) @(negedge clk);
        chk(32'(ready), 1, "R8");
        chk(32'(pd), 0, "R9");

        // R10: busy also blocks power-down entry
        busy = 1'b1;
        xfer(8'hB9, 8, 0, "R10");
        chk(32'(pd), 0, "R10");
        busy = 1'b0;

        // R11: partial command discarded, next one realigned
        xfer(8'hB9, 4, 0, "R11");
        chk(32'(pd), 0, "R11");
        xfer(8'hB9, 8, 0, "R11");
        chk(32'(pd), 1, "R11");

        wait_clk(5);
        chk(32'(exp_q.size()), 0, "R5");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule